// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the device side of a single-bit SPI serial flash, reduced to one command: the fast read. After chip select falls, the master clocks in an 8-bit opcode, a 24-bit start address and one dummy byte. The block then streams bytes from its internal byte array for as long as the master keeps clocking. It steps the address by one after every byte, and the 24-bit address wraps from its top value to zero.

The byte array is loaded beforehand through a synchronous parallel write port. The serial clock, serial data in and chip select are sampled on the system clock `clk`, which must run several times faster than the serial clock. The data output comes with an enable that drives an external tri-state pad. While the enable is low, the output counts as high impedance. An external busy flag marks a write cycle in progress, and a command that meets it is refused.

Top module: `fastread_responder`

## Requirements
- R1: After reset, and while chip select (`cs_n`) is high, `sdo_en` is 0.
- R2: With `cs_n` low, the block samples `sdi` on each rising edge of `sclk`, MSB first, in this order: an 8-bit opcode, a 24-bit address, then 8 dummy bits. The total is 40 rising edges.
- R3: Only opcode 8'h0B is accepted. Any other opcode keeps `sdo_en` at 0 until `cs_n` rises, however many clocks follow.
- R4: Read data goes out MSB first. `sdo` changes only after a falling edge of `sclk`. The first data bit is driven after the falling edge that ends the 40th clock.
- R5: After the 8th bit of a byte, the address advances by one, and the next byte follows without any gap.
- R6: The 24-bit address wraps from 24'hFFFFFF to 24'h000000. The byte array is indexed by the low MEM_AW address bits only.
- R7: Raising `cs_n` at any point, including mid-byte, drops `sdo_en` on the next `clk` edge and restarts the bit count. The next command decodes from its first bit.
- R8: If `busy` is high at any header rising edge, the command is refused, and `sdo_en` stays 0 until `cs_n` rises.
- R9: With `wr_en` high, `wr_data` is written to array entry `wr_addr` on the rising edge of `clk`. Later reads return the written value.
- R10: `sdo_en` stays 0 for all 40 header clocks and rises only together with the first data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master (idles low) |
| sdi | input | 1 | Serial data from the master |
| busy | input | 1 | High while a write cycle is in progress |
| wr_en | input | 1 | Parallel preload write strobe |
| wr_addr | input | MEM_AW | Preload byte index |
| wr_data | input | 8 | Preload byte value |
| sdo | output | 1 | Serial data to the master |
| sdo_en | output | 1 | Output enable for the tri-state pad |

## Verification
The hardest conditions to reach are the 24-bit wrap and the mid-byte abort. The wrap only appears after a read runs past the top of the address range. The bench therefore starts a read at 24'hFFFFFE and clocks four bytes, so the counter crosses from all ones to zero inside one command. For the abort, the bench raises chip select after three data bits. It then issues a new command and checks that the header count restarted, which shows because the new start address is decoded correctly. For the busy case, the flag is raised during a single address bit only, to show that a short pulse is enough to refuse the command.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_DROP = 2'd2
    } phase_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/fr_edge.sv
module fr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/fr_mem.sv
module fr_mem #(
    parameter int AW = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [fr_pkg::BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [fr_pkg::BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [fr_pkg::BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/fastread_responder.sv
module fastread_responder #(
    parameter int         MEM_AW = 8,
    parameter int         ADDR_W = 24,
    parameter logic [7:0] OPCODE = 8'h0B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              sdo,
    output logic              sdo_en
);
    import fr_pkg::*;

    localparam int CMD_W    = 8;
    localparam int DUMMY_W  = 8;
    localparam int SH_W     = CMD_W + ADDR_W;
    localparam int HDR_BITS = SH_W + DUMMY_W;
    localparam int CNT_W    = $clog2(HDR_BITS + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(SH_W - 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [SH_W-1:0]     shreg;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   obyte;
        logic [2:0]          bidx;
        logic                sdo;
        logic                sdo_en;
        logic                busy_seen;
    } st_t;

    st_t q, d;

    logic              rise_w, fall_w;
    logic [BYTE_W-1:0] rd_data;
    logic [SH_W-1:0]   sh_nxt;

    fr_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sclk),
        .rise  (rise_w),
        .fall  (fall_w)
    );

    fr_mem #(.AW(MEM_AW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (q.addr[MEM_AW-1:0]),
        .rd_data (rd_data)
    );

    assign sh_nxt = {q.shreg[SH_W-2:0], sdi};

    always_comb begin
        d = q;
        if (cs_n) begin
            d = '0;
        end else begin
            case (q.phase)
                PH_HDR: begin
                    if (rise_w) begin
                        d.shreg     = sh_nxt;
                        d.busy_seen = q.busy_seen | busy;
                        d.cnt       = q.cnt + 1'b1;
                        if (q.cnt == CMD_LAST && sh_nxt[CMD_W-1:0] != OPCODE)
                            d.phase = PH_DROP;
                        if (q.cnt == ADDR_LAST)
                            d.addr = sh_nxt[ADDR_W-1:0];
                        if (q.cnt == HDR_LAST)
                            d.phase = (q.busy_seen | busy) ? PH_DROP : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (fall_w) begin
                        d.sdo_en = 1'b1;
                        if (q.bidx == 3'd0) begin
                            d.sdo   = rd_data[BYTE_W-1];
                            d.obyte = {rd_data[BYTE_W-2:0], 1'b0};
                            d.bidx  = 3'd7;
                        end else begin
                            d.sdo   = q.obyte[BYTE_W-1];
                            d.obyte = {q.obyte[BYTE_W-2:0], 1'b0};
                            d.bidx  = q.bidx - 1'b1;
                            if (q.bidx == 3'd1)
                                d.addr = q.addr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo    = q.sdo;
    assign sdo_en = q.sdo_en;

    AST_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_en); // R7

    AST_EN_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> q.phase == PH_DATA); // R10

    AST_DROP_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase == PH_DROP |-> !sdo_en); // R3

    AST_HDR_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase == PH_HDR |-> q.cnt <= HDR_LAST); // R2

    AST_ADDR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DATA && $past(q.phase) == PH_DATA)
        |-> (q.addr == $past(q.addr) || q.addr == ADDR_W'($past(q.addr) + 1'b1))); // R5

    AST_SDO_HOLDS_OFF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fall_w) && !$past(cs_n) && $past(q.phase) == PH_DATA)
        |-> $stable(sdo)); // R4
endmodule

// File: tb/fastread_responder_test.sv
module fastread_responder_test;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic busy = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic sdo, sdo_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #10 clk = ~clk;

    fastread_responder #(.MEM_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse();
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model[a] = v;
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [23:0] a, input int busy_bit);
        logic [39:0] frame;
        frame = {op, a, 8'hA5};
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 39; i >= 0; i--) begin
            @(negedge clk);
            sdi  = frame[i];
            busy = (i == busy_bit);
            check("R10 header enable", sdo_en, 1'b0);
            pulse();
        end
        busy = 1'b0;
    endtask

    task automatic read_bytes(input logic [23:0] a, input int n, input string req);
        logic [23:0] ad;
        ad = a;
        for (int b = 0; b < n; b++) begin
            for (int k = 7; k >= 0; k--) begin
                repeat (2) @(negedge clk);
                check({req, " enable"}, sdo_en, 1'b1);
                check({req, " data bit"}, sdo, model[ad[7:0]][k]);
                sclk = 1'b1;
                repeat (2) @(negedge clk);
                sclk = 1'b0;
            end
            ad = ad + 1'b1;
        end
    endtask

    task automatic deselect();
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 deselect drops enable", sdo_en, 1'b0);
    endtask

    task automatic expect_silent(input int nbits, input string req);
        for (int i = 0; i < nbits; i++) begin
            pulse();
            @(negedge clk);
            check(req, sdo_en, 1'b0);
        end
    endtask

    task automatic t_reset();
        check("R1 reset enable", sdo_en, 1'b0);
    endtask

    task automatic t_preload();
        for (int i = 0; i < 256; i++)
            poke(8'(i), 8'((i * 37 + 11) ^ 8'h5C));
    endtask

    task automatic t_basic();
        send_hdr(8'h0B, 24'h000010, -1);
        read_bytes(24'h000010, 4, "R4 R5 basic read");
        deselect();
    endtask

    task automatic t_wrap();
        send_hdr(8'h0B, 24'hFFFFFE, -1);
        read_bytes(24'hFFFFFE, 4, "R6 wrap");
        deselect();
        send_hdr(8'h0B, 24'h12_34FF, -1);
        read_bytes(24'h1234FF, 2, "R6 high bits ignored");
        deselect();
    endtask

    task automatic t_bad_opcode();
        send_hdr(8'h03, 24'h000020, -1);
        expect_silent(24, "R3 wrong opcode");
        deselect();
    endtask

    task automatic t_busy();
        send_hdr(8'h0B, 24'h000030, 20);
        expect_silent(24, "R8 busy reject");
        deselect();
        send_hdr(8'h0B, 24'h000030, -1);
        read_bytes(24'h000030, 1, "R8 after busy");
        deselect();
    endtask

    task automatic t_abort();
        send_hdr(8'h0B, 24'h000040, -1);
        for (int k = 0; k < 3; k++) pulse();
        deselect();
        send_hdr(8'h0B, 24'h000080, -1);
        read_bytes(24'h000080, 2, "R7 restart after abort");
        deselect();
    endtask

    task automatic t_rewrite();
        poke(8'h91, 8'hC3);
        poke(8'h92, 8'h3C);
        send_hdr(8'h0B, 24'h000091, -1);
        read_bytes(24'h000091, 2, "R9 rewrite");
        deselect();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_preload();
        t_basic();
        t_wrap();
        t_bad_opcode();
        t_busy();
        t_abort();
        t_rewrite();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule